// File: doc/BRIEF.md
# UART Register Front End with Busy Guard

This block is the register-access side of a 16550-style serial port. It answers single-cycle register reads and writes from an APB-like bus, holds the line control, interrupt enable and interrupt identification logic, and exposes an extra status register whose low bit mirrors the serial core's busy indication. Shift engines, baud generation and FIFOs live elsewhere. They reach this block only as a busy level and four interrupt source levels (line status, receive data, receive timeout and transmit holding empty).

Line control must not change while a character is moving, so a line-control write that lands while the core is busy is dropped. Software finds out by reading line control back. The dropped write also latches a busy-detect interrupt. This interrupt has the lowest priority in the identification code and only a read of the status register clears it.

Every register is 8 bits wide and sits in a 32-bit slot. The register index is the byte address divided by four, and bits 31:8 of read data are zero. An access takes place in the cycle where `psel` and `penable` are both high. Write effects land on that clock edge, and read data is valid during that cycle. There is no wait state and no error response. Since the bus carries a single register access per cycle, no back-pressure applies.

Top module: `uart_regfront`

## Requirements
- R1: After reset, line control reads 0x00, interrupt enable reads 0x00, identification reads 0x01 and `irq` is low.
- R2: The register index is `paddr[7:2]`. Address bits 1:0 do not affect which register is hit, and `prdata[31:8]` is always zero.
- R3: The status register sits at index 0x1F (byte 0x7C). Its bit 0 reads the current `core_busy` level and its other bits read zero.
- R4: A line-control write (index 3) with `core_busy` low stores `pwdata[7:0]` on that edge. A read of index 3 returns the stored value.
- R5: A line-control write with `core_busy` high leaves line control unchanged.
- R6: A rejected line-control write makes the busy-detect condition pending. With no other source active, identification (index 2) reads 0x07.
- R7: A read of the status register clears a pending busy-detect condition.
- R8: Identification bits 3:0 follow a fixed priority: line status 0x6 (enable bit 2), then receive data 0x4 (enable bit 0), then receive timeout 0xC (enable bit 0), then holding empty 0x2 (enable bit 1), then busy-detect 0x7 (not maskable), and 0x1 when nothing is pending. Bits 7:4 read zero.
- R9: `irq` is high exactly when an enabled source or the busy-detect condition is pending.
- R10: Interrupt enable (index 1) stores `pwdata[2:0]` and reads back with bits 7:3 zero.
- R11: Writes to identification, status or unmapped indices change no register. Reads of unmapped indices return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase; an access occurs when both select and enable are high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data; only bits 7:0 are used |
| prdata | output | 32 | Read data, valid during the access cycle |
| core_busy | input | 1 | Serial core is moving a character |
| src_line | input | 1 | Line-status interrupt source level |
| src_rx | input | 1 | Receive-data interrupt source level |
| src_timeout | input | 1 | Receive-timeout interrupt source level |
| src_thre | input | 1 | Transmit-holding-empty interrupt source level |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check that accepted line-control writes land and that rejected ones leave line control untouched. They also check that a rejected write raises busy-detect and a status read drops it, that `irq` agrees with the identification code, that the status read returns the busy level, and that the upper read bits are zero. Only the bench scenarios can show the software-visible sequence: a write dropped while busy, found by reading back, then identification 0x07, then a status read that clears it. The same holds for the full priority order under overlapping sources, address aliasing through the low bits, and the absence of any effect from writes to read-only or unmapped slots.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
  localparam int unsigned REG_W = 8;

  localparam logic [5:0] IDX_IER = 6'h01;
  localparam logic [5:0] IDX_IIR = 6'h02;
  localparam logic [5:0] IDX_LCR = 6'h03;
  localparam logic [5:0] IDX_USR = 6'h1F;

  typedef enum logic [3:0] {
    IID_NONE = 4'h1,
    IID_THRE = 4'h2,
    IID_RX   = 4'h4,
    IID_LINE = 4'h6,
    IID_BUSY = 4'h7,
    IID_TMO  = 4'hC
  } iid_e;

  typedef struct packed {
    logic line;
    logic rx;
    logic tmo;
    logic thre;
  } irq_src_t;

  typedef struct packed {
    logic wr_ier;
    logic wr_lcr;
    logic rd_usr;
  } reg_hit_t;
endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
  import uart_regfront_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic [IDX_W-1:0]  idx,
  output logic              rd_acc,
  output reg_hit_t          hit
);
  logic acc;
  logic unused_lsb;

  assign acc        = psel & penable;
  assign idx        = paddr[ADDR_W-1:2];
  assign unused_lsb = ^paddr[1:0];
  assign rd_acc     = acc & ~pwrite;

  always_comb begin
    hit        = '0;
    hit.wr_ier = acc & pwrite & (idx == IDX_W'(IDX_IER));
    hit.wr_lcr = acc & pwrite & (idx == IDX_W'(IDX_LCR));
    hit.rd_usr = rd_acc & (idx == IDX_W'(IDX_USR));
  end
endmodule

// File: rtl/uart_lcr_guard.sv
module uart_lcr_guard
  import uart_regfront_pkg::*;
#(
  parameter logic [REG_W-1:0] LCR_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lcr,
  input  logic             busy,
  input  logic [REG_W-1:0] wdata,
  input  logic             rd_usr,
  output logic [REG_W-1:0] lcr,
  output logic             busy_pend
);
  logic take;
  logic reject;

  assign take   = wr_lcr & ~busy;
  assign reject = wr_lcr & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr <= LCR_RST;
    end else if (take) begin
      lcr <= wdata;
    end
  end

  // a fresh rejection outranks a clearing read in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_pend <= 1'b0;
    end else if (reject) begin
      busy_pend <= 1'b1;
    end else if (rd_usr) begin
      busy_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_regfront_pkg::*;
#(
  parameter int unsigned IER_W = 3
) (
  input  logic [IER_W-1:0] ier,
  input  irq_src_t         src,
  input  logic             busy_pend,
  output iid_e             iid,
  output logic             irq
);
  localparam int unsigned N_SRC = 5;

  logic [N_SRC-1:0] act;
  iid_e             code [N_SRC];

  assign act[0] = src.line & ier[2];
  assign act[1] = src.rx   & ier[0];
  assign act[2] = src.tmo  & ier[0];
  assign act[3] = src.thre & ier[1];
  assign act[4] = busy_pend;

  assign code[0] = IID_LINE;
  assign code[1] = IID_RX;
  assign code[2] = IID_TMO;
  assign code[3] = IID_THRE;
  assign code[4] = IID_BUSY;

  always_comb begin
    iid = IID_NONE;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (act[i]) iid = code[i];
    end
  end

  assign irq = |act;
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IER_W  = 3,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              core_busy,
  input  logic              src_line,
  input  logic              src_rx,
  input  logic              src_timeout,
  input  logic              src_thre,
  output logic              irq
);
  logic [IDX_W-1:0] idx;
  logic             rd_acc;
  reg_hit_t         hit;
  logic [REG_W-1:0] lcr_q;
  logic             busy_pend_q;
  logic [IER_W-1:0] ier_q;
  iid_e             iid;
  irq_src_t         src;
  logic [REG_W-1:0] rd_byte;
  logic             unused_wbits;

  assign unused_wbits = ^pwdata[DATA_W-1:REG_W];

  assign src.line = src_line;
  assign src.rx   = src_rx;
  assign src.tmo  = src_timeout;
  assign src.thre = src_thre;

  uart_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .idx     (idx),
    .rd_acc  (rd_acc),
    .hit     (hit)
  );

  uart_lcr_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lcr    (hit.wr_lcr),
    .busy      (core_busy),
    .wdata     (pwdata[REG_W-1:0]),
    .rd_usr    (hit.rd_usr),
    .lcr       (lcr_q),
    .busy_pend (busy_pend_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0;
    end else if (hit.wr_ier) begin
      ier_q <= pwdata[IER_W-1:0];
    end
  end

  uart_irq_prio #(.IER_W(IER_W)) u_prio (
    .ier       (ier_q),
    .src       (src),
    .busy_pend (busy_pend_q),
    .iid       (iid),
    .irq       (irq)
  );

  always_comb begin
    rd_byte = '0;
    if (rd_acc) begin
      case (idx)
        IDX_W'(IDX_IER): rd_byte = REG_W'(ier_q);
        IDX_W'(IDX_IIR): rd_byte = REG_W'(iid);
        IDX_W'(IDX_LCR): rd_byte = lcr_q;
        IDX_W'(IDX_USR): rd_byte = REG_W'(core_busy);
        default:         rd_byte = '0;
      endcase
    end
  end

  assign prdata = DATA_W'(rd_byte);
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk
  import uart_regfront_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic              core_busy,
  input logic              irq,
  input logic [REG_W-1:0]  lcr_q,
  input logic              busy_pend_q,
  input logic [3:0]        iid
);
  logic acc_w, acc_r, at_lcr, at_usr;
  assign acc_w  = psel & penable & pwrite;
  assign acc_r  = psel & penable & ~pwrite;
  assign at_lcr = paddr[ADDR_W-1:2] == (ADDR_W-2)'(IDX_LCR);
  assign at_usr = paddr[ADDR_W-1:2] == (ADDR_W-2)'(IDX_USR);

  // R4
  lcr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_w && at_lcr && !core_busy) |=> (lcr_q == $past(pwdata[REG_W-1:0])));

  // R5
  lcr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_w && at_lcr && core_busy) |=> $stable(lcr_q));

  // R6
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_w && at_lcr && core_busy) |=> busy_pend_q);

  // R7
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_r && at_usr) |=> !busy_pend_q);

  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iid != 4'h1));

  // R3
  usr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_r && at_usr) |-> (prdata == DATA_W'(core_busy)));

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prdata[DATA_W-1:REG_W] == '0);
endmodule

bind uart_regfront uart_regfront_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .psel        (psel),
  .penable     (penable),
  .pwrite      (pwrite),
  .paddr       (paddr),
  .pwdata      (pwdata),
  .prdata      (prdata),
  .core_busy   (core_busy),
  .irq         (irq),
  .lcr_q       (lcr_q),
  .busy_pend_q (busy_pend_q),
  .iid         (iid)
);

// File: tb/uart_regfront_bench.sv
`timescale 1ns/1ps
module uart_regfront_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        core_busy = 1'b0;
  logic        s_line = 1'b0, s_rx = 1'b0, s_tmo = 1'b0, s_thre = 1'b0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] m_lcr = 8'h00;
  logic [2:0] m_ier = 3'h0;
  logic       m_bp  = 1'b0;

  always #5 clk = ~clk;

  uart_regfront u_uart_regfront (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .core_busy(core_busy),
    .src_line(s_line), .src_rx(s_rx), .src_timeout(s_tmo), .src_thre(s_thre),
    .irq(irq)
  );

  function automatic logic [7:0] exp_iir();
    if (s_line && m_ier[2]) return 8'h06;
    if (s_rx && m_ier[0])   return 8'h04;
    if (s_tmo && m_ier[0])  return 8'h0C;
    if (s_thre && m_ier[1]) return 8'h02;
    if (m_bp)               return 8'h07;
    return 8'h01;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a[7:2])
      6'h01:   return {29'd0, m_ier};
      6'h02:   return {24'd0, exp_iir()};
      6'h03:   return {24'd0, m_lcr};
      6'h1F:   return {31'd0, core_busy};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus access; read data is compared in the access cycle, model updated after the edge
  task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    if (!wr) check(req, prdata, exp_read(a));
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    if (wr) begin
      if (a[7:2] == 6'h03) begin
        if (core_busy) m_bp = 1'b1;
        else m_lcr = d[7:0];
      end else if (a[7:2] == 6'h01) begin
        m_ier = d[2:0];
      end
    end else if (a[7:2] == 6'h1F) begin
      m_bp = 1'b0;
    end
    check({req, " irq (R9)"}, {31'd0, irq}, {31'd0, exp_iir() != 8'h01});
  endtask

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    access(1'b0, 8'h0C, 0, "R1 lcr");
    access(1'b0, 8'h04, 0, "R1 ier");
    access(1'b0, 8'h08, 0, "R1 iir");
    check("R1 irq", {31'd0, irq}, 32'd0);
    // R4 accepted write and readback
    access(1'b1, 8'h0C, 32'hFFFF_FF9B, "R4 write");
    access(1'b0, 8'h0C, 0, "R4 readback");
    // R2 low address bits ignored
    access(1'b0, 8'h0F, 0, "R2 alias");
    // R5 / R6 rejected write
    core_busy = 1'b1;
    access(1'b1, 8'h0C, 32'h0000_0044, "R5 busy write");
    access(1'b0, 8'h0C, 0, "R5 lcr kept");
    check("R5 lcr unchanged", {24'd0, m_lcr}, 32'h9B);
    access(1'b0, 8'h08, 0, "R6 iir busy");
    check("R6 irq", {31'd0, irq}, 32'd1);
    // R3 / R7 status read clears
    access(1'b0, 8'h7C, 0, "R3 usr busy");
    access(1'b0, 8'h08, 0, "R7 cleared");
    core_busy = 1'b0;
    access(1'b0, 8'h7C, 0, "R3 usr idle");
    // R10 enable register
    access(1'b1, 8'h04, 32'h0000_00FF, "R10 ier");
    access(1'b0, 8'h04, 0, "R10 ier read");
    // R8 priority ladder
    s_line = 1; s_rx = 1; s_tmo = 1; s_thre = 1;
    access(1'b0, 8'h08, 0, "R8 line");
    s_line = 0; access(1'b0, 8'h08, 0, "R8 rx");
    s_rx = 0;   access(1'b0, 8'h08, 0, "R8 tmo");
    s_tmo = 0;  access(1'b0, 8'h08, 0, "R8 thre");
    core_busy = 1'b1;
    access(1'b1, 8'h0C, 32'h11, "R8 make busy");
    access(1'b0, 8'h08, 0, "R8 thre over busy");
    s_thre = 0; access(1'b0, 8'h08, 0, "R8 busy lowest");
    // R11 writes with no effect
    access(1'b1, 8'h7C, 32'hFF, "R11 usr write");
    access(1'b1, 8'h08, 32'hFF, "R11 iir write");
    access(1'b1, 8'h40, 32'hFF, "R11 unmapped write");
    access(1'b0, 8'h40, 0, "R11 unmapped read");
    access(1'b0, 8'h08, 0, "R11 iir still busy");
    access(1'b0, 8'h0C, 0, "R11 lcr intact");
    access(1'b0, 8'h04, 0, "R11 ier intact");
    core_busy = 1'b0;
    access(1'b0, 8'h7C, 0, "R7 clear again");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 7));
      case (pick)
        3'd0, 3'd1: a = {6'h03, 2'($urandom)};
        3'd2: a = {6'h01, 2'($urandom)};
        3'd3: a = {6'h02, 2'($urandom)};
        3'd4: a = {6'h1F, 2'($urandom)};
        default: a = 8'($urandom);
      endcase
      core_busy = 1'($urandom);
      s_line = ($urandom_range(0, 7) == 0);
      s_rx   = ($urandom_range(0, 5) == 0);
      s_tmo  = ($urandom_range(0, 5) == 0);
      s_thre = ($urandom_range(0, 3) == 0);
      access(1'($urandom), a, $urandom, "R8 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule